// File: doc/BRIEF.md
# Quarter-Stride Four-Bank Reorder Buffer

This block sits in front of a radix-4 butterfly stage. Complex samples enter four at a time, in natural order: accepted beat `c` carries elements `4c` through `4c+3` of the frame. After a whole frame has arrived, the block returns it as groups of four in which the members of each group lie one quarter-frame apart. Group `i` therefore holds elements `i`, `i+N/4`, `i+N/2` and `i+3N/4`, which is exactly the set a butterfly consumes together.

Storage is split across four banks. Each bank has one write port and one read port that are used in the same cycle. On the write side, a lane rotator shifts the lane-to-bank mapping by one more position for each quarter of the frame. The four members of every output group therefore sit in four different banks and can be read in a single cycle. An inverse rotator on the read side puts the lanes back in order. Each bank holds two frames, so one frame can be read out while the next one is being written, and back-to-back frames stream with no gap.

A frame begins with a start marker on its first beat. The frame size is a parameter and must be a power of four, 16 points or more. Each sample is 32 bits: the real part is in the low 16 bits and the imaginary part in the high 16 bits. Both parts pass through unchanged.

Top module: `quad_stride_reorder`

## Requirements
- R1: While the block is in reset, and afterwards until the first complete frame has been accepted, `out_valid` stays 0. A frame that is only partly written when reset is applied never produces output.
- R2: The first output group of a frame appears in the cycle right after the edge that accepts that frame's last beat. `out_valid` then stays high for exactly N/4 consecutive cycles, unless a following frame keeps it high.
- R3: Output group `i` (counted from 0 within the frame) carries element `i + j*N/4` on lane `j`. Here element `e` is lane `e mod 4` of accepted beat `e div 4`, lane `j` occupies bits `[32j+31:32j]`, and every sample appears bit-exact.
- R4: When frames arrive back to back, the groups of one frame follow those of the previous frame with no idle cycle between them.
- R5: Cycles with `in_valid` low in the middle of a frame pause the frame without changing its content or order. Output starts the cycle after the last beat, whenever that beat arrives.
- R6: A beat with `in_sof` high always becomes beat 0 of a new frame. Any partly written frame is abandoned and produces no output.
- R7: A beat with `in_valid` high and `in_sof` low that arrives while no frame is in progress is ignored. It produces no output and does not alter the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input beat qualifier |
| in_sof | input | 1 | Marks the first beat of a frame |
| in_data | input | 128 | Four input samples, lane 0 in the low 32 bits |
| out_valid | output | 1 | Output group qualifier |
| out_data | output | 128 | Four reordered samples, lane 0 in the low 32 bits |

## Verification
The hardest situation to reach is the one where a frame's last beat is accepted on the same edge that the read side issues the final group of the previous frame. Page swap, reader restart and bank reuse all meet on that edge. The stimulus table drives frames with no idle cycle between them, so that edge recurs. It also mixes in frames with idle gaps at different beat positions, which moves the same hand-over to other alignments. Directed sequences then start a frame and restart it mid-way with a new start marker, send stray beats with no start marker, and apply reset while a frame is partly written. Each is followed by a complete frame whose content and timing are checked lane by lane.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
  localparam int LANES = 4;
  localparam int LSW   = 2;
  typedef logic [LSW-1:0] lane_t;
endpackage

// File: rtl/qsr_bank.sv
module qsr_bank #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int ENTRIES = 2 ** AW;
  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qsr_wr_ctrl.sv
module qsr_wr_ctrl
  import qsr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          we,
  output logic [AW-1:0] beat,
  output lane_t         rot,
  output logic          page,
  output logic          busy,
  output logic [AW-1:0] cnt,
  output logic          frame_done
);
  localparam int QSH = AW - 2;

  logic          busy_q, busy_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          page_q, page_d;

  always_comb begin
    we         = in_valid & (in_sof | busy_q);
    beat       = in_sof ? '0 : cnt_q;
    rot        = lane_t'(beat >> QSH);
    frame_done = we && (beat == AW'(DEPTH - 1));
    cnt_d      = cnt_q;
    busy_d     = busy_q;
    page_d     = page_q;
    if (frame_done) begin
      cnt_d  = '0;
      busy_d = 1'b0;
      page_d = ~page_q;
    end else if (we) begin
      cnt_d  = beat + AW'(1);
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= 1'b0;
    end else if (we) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  assign page = page_q;
  assign busy = busy_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/qsr_rd_ctrl.sv
module qsr_rd_ctrl #(
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_page,
  output logic          valid,
  output logic [AW-1:0] idx,
  output logic          page
);
  logic          busy_q, busy_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          page_q, page_d;
  logic          en;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    page_d = page_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      page_d = start_page;
    end else if (busy_q) begin
      if (idx_q == AW'(DEPTH - 1)) busy_d = 1'b0;
      idx_d = idx_q + AW'(1);
    end
    en = start | busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      page_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      page_q <= page_d;
    end
  end

  assign valid = busy_q;
  assign idx   = idx_q;
  assign page  = page_q;
endmodule

// File: rtl/quad_stride_reorder.sv
module quad_stride_reorder
  import qsr_pkg::*;
#(
  parameter int FRAME_PTS = 16,
  parameter int SAMPLE_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic [LANES*SAMPLE_W-1:0] in_data,
  output logic                      out_valid,
  output logic [LANES*SAMPLE_W-1:0] out_data
);
  localparam int DEPTH = FRAME_PTS / LANES;
  localparam int AW    = $clog2(DEPTH);
  localparam int QSTR  = DEPTH / LANES;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic          wr_en, wr_page, wr_busy, frame_done;
  logic [AW-1:0] wr_beat, wr_cnt;
  lane_t         wr_rot;
  logic          rd_valid, rd_page;
  logic [AW-1:0] rd_idx;

  qsr_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_sof(in_sof),
    .we(wr_en), .beat(wr_beat), .rot(wr_rot), .page(wr_page),
    .busy(wr_busy), .cnt(wr_cnt), .frame_done(frame_done)
  );

  qsr_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .start(frame_done), .start_page(wr_page),
    .valid(rd_valid), .idx(rd_idx), .page(rd_page)
  );

  lane_t         rd_lane;
  logic [AW-1:0] rd_quad;
  assign rd_lane = lane_t'(rd_idx);
  assign rd_quad = rd_idx >> 2;

  logic [SAMPLE_W-1:0] bank_rd [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    lane_t               src_lane;
    lane_t               grp_pos;
    logic [SAMPLE_W-1:0] wdata;
    logic [AW:0]         waddr, raddr;

    assign src_lane = lane_t'(b) - wr_rot;
    assign wdata    = in_data[src_lane*SAMPLE_W +: SAMPLE_W];
    assign waddr    = {wr_page, wr_beat};
    assign grp_pos  = lane_t'(b) - rd_lane;
    assign raddr    = {rd_page, rd_quad + AW'(grp_pos) * AW'(QSTR)};

    qsr_bank #(.W(SAMPLE_W), .AW(AW + 1)) u_bank (
      .clk(clk), .we(wr_en), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(bank_rd[b])
    );
  end

  for (genvar j = 0; j < LANES; j++) begin : g_out
    lane_t src_bank;
    assign src_bank = rd_lane + lane_t'(j);
    assign out_data[j*SAMPLE_W +: SAMPLE_W] = bank_rd[src_bank];
  end

  assign out_valid = rd_valid;
endmodule

// File: rtl/qsr_checker.sv
module qsr_checker #(
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic          out_valid,
  input logic          wr_busy,
  input logic [AW-1:0] wr_cnt
);
  logic          m_busy, seen;
  logic [AW-1:0] m_cnt, o_cnt;
  logic          m_acc, m_last;
  logic [AW-1:0] m_beat;

  always_comb begin
    m_acc  = in_valid && (in_sof || m_busy);
    m_beat = in_sof ? '0 : m_cnt;
    m_last = m_acc && (m_beat == AW'(DEPTH - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= '0;
      seen   <= 1'b0;
      o_cnt  <= '0;
    end else begin
      if (m_acc) begin
        m_busy <= !m_last;
        m_cnt  <= m_last ? '0 : m_beat + AW'(1);
      end
      if (m_last) seen <= 1'b1;
      if (out_valid) o_cnt <= o_cnt + AW'(1);
    end
  end

  assert_quiet_until_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !out_valid);

  assert_out_after_last_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |=> out_valid);

  assert_burst_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_cnt == AW'(DEPTH - 1) && !m_last) |=> !out_valid);

  assert_burst_unbroken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_cnt != '0) |-> out_valid);

  assert_sof_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (wr_busy && wr_cnt == AW'(1)));

  assert_stray_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !wr_busy) |=> (!wr_busy && wr_cnt == '0));
endmodule

bind quad_stride_reorder qsr_checker #(.DEPTH(FRAME_PTS / 4)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .wr_busy(wr_busy), .wr_cnt(wr_cnt)
);

// File: tb/sim_quad_stride_reorder.sv
module sim_quad_stride_reorder;
  localparam int FRAME_PTS = 16;
  localparam int SW        = 32;
  localparam int D         = FRAME_PTS / 4;

  // {seed[23:8], idle-before-beat mask[7:4], idle cycles after frame[3:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h1234_0_0, 24'h8000_0_0, 24'h7FFF_5_0,
    24'hA5A5_A_2, 24'h0001_F_0, 24'hFFFF_0_3
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid, in_sof;
  logic [4*SW-1:0] in_data;
  logic          out_valid;
  logic [4*SW-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  int nw = 0, nr = 0, grp = 0;
  logic [15:0] exp_seed [64];
  int          exp_last [64];
  string       exp_tag  [64];
  bit          done = 1'b0;

  quad_stride_reorder #(.FRAME_PTS(FRAME_PTS), .SAMPLE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] smp(input logic [15:0] s, input int e);
    logic [15:0] e16;
    e16 = 16'(e);
    return {s ^ (e16 * 16'h0101), s + e16 * 16'h0F11};
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_data  = {4{32'hDEAD_BEEF}};
  endtask

  task automatic drive_beat(input bit sof, input logic [15:0] seed, input int b);
    in_valid = 1'b1;
    in_sof   = sof;
    for (int l = 0; l < 4; l++) in_data[l*SW +: SW] = smp(seed, 4*b + l);
  endtask

  task automatic send_frame(input logic [15:0] seed, input logic [3:0] gaps, input string tag);
    for (int b = 0; b < D; b++) begin
      if (gaps[b % 4]) begin
        idle();
        step();
      end
      drive_beat(b == 0, seed, b);
      if (b == D - 1) begin
        exp_seed[nw % 64] = seed;
        exp_last[nw % 64] = cyc;
        exp_tag[nw % 64]  = tag;
        nw++;
      end
      step();
    end
    idle();
  endtask

  // output monitor: timing (R2 R4 R5) and lane content (R3)
  always @(negedge clk) begin
    if (out_valid) begin
      if (nr >= nw) begin
        check(1'b0, "R6 R7 output with no complete frame", 1, 0);
      end else begin
        if (grp == 0)
          check(cyc == exp_last[nr % 64] + 1, {exp_tag[nr % 64], " R2 first group cycle"},
                cyc, exp_last[nr % 64] + 1);
        for (int j = 0; j < 4; j++)
          check(out_data[j*SW +: SW] == smp(exp_seed[nr % 64], grp + j*D),
                {exp_tag[nr % 64], " R3 lane data"},
                out_data[j*SW +: SW], smp(exp_seed[nr % 64], grp + j*D));
        grp++;
        if (grp == D) begin
          grp = 0;
          nr++;
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired act=%0d exp=%0d", cyc, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) step();
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) step();
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // table walk: back-to-back frames (R4), gapped frames (R5)
    for (int v = 0; v < 6; v++) begin
      send_frame(VEC[v][23:8], VEC[v][7:4], (VEC[v][7:4] != 0) ? "R5" : "R4");
      repeat (int'(VEC[v][3:0])) step();
    end
    repeat (D + 3) step();

    // R7: stray beats with no start marker
    for (int b = 0; b < 3; b++) begin
      drive_beat(1'b0, 16'h9999, b);
      step();
    end
    idle();
    repeat (D + 2) step();
    check(nr == nw, "R7 stray beats produced output", nr, nw);
    send_frame(16'h3C3C, 4'h0, "R7");
    repeat (2) step();

    // R6: restart mid-frame
    drive_beat(1'b1, 16'h1111, 0);
    step();
    drive_beat(1'b0, 16'h1111, 1);
    step();
    send_frame(16'h2222, 4'h0, "R6");
    repeat (D + 3) step();

    // R1: reset with a partial frame
    drive_beat(1'b1, 16'h4444, 0);
    step();
    drive_beat(1'b0, 16'h4444, 1);
    step();
    idle();
    rst_n = 1'b0;
    repeat (2) step();
    check(out_valid == 1'b0, "R1 out_valid during mid-frame reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) step();
    check(out_valid == 1'b0, "R1 partial frame leaked after reset", out_valid, 0);
    send_frame(16'h5555, 4'h2, "R1");
    repeat (D + 4) step();

    check(nr == nw, "R6 R7 complete frame count", nr, nw);
    check(grp == 0, "R2 group count per frame", grp, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule